// File: doc/BRIEF.md
# Dual-Polarisation Spectral Correlator

This block sits behind a polyphase filterbank that delivers two channel-multiplexed streams of complex samples, one for each receiver polarisation (X and Y). On every accepted beat both streams carry the same frequency channel. For each such pair the block computes the two power terms, |X|² and |Y|², and the real and imaginary parts of the cross term X·conj(Y). These four results go out together on one bus, tagged with the channel number and a start-of-spectrum marker, to an integrator further down the chain.

Internally every term is kept at full precision (33 bits for 16-bit inputs). A static configuration input then picks the window of bits that reaches the 16-bit output lanes. Results outside the lane range are clamped rather than wrapped. The pipeline moves only on beats where the input is valid, so gaps in the input stream produce gaps in the output and cause no loss or repetition of samples.

Top module: `dual_pol_correlator`

## Requirements
- R1: While reset is held low and straight after it, outValid and outSos are 0 and corrOut and outChan are all zeros.
- R2: Lane 0 of corrOut (bits 15:0) carries the X power xRe²+xIm² as an unsigned number, after the shift of R8 and the clamp of R9.
- R3: Lane 1 (bits 31:16) carries the Y power yRe²+yIm² as an unsigned number, after the shift and the clamp.
- R4: Lane 2 (bits 47:32) carries the real cross term xRe·yRe + xIm·yIm as a signed two's-complement number, after the shift and the clamp.
- R5: Lane 3 (bits 63:48) carries the imaginary cross term xIm·yRe − xRe·yIm as a signed two's-complement number, after the shift and the clamp.
- R6: The result of the k-th valid input beat appears, with outValid high, right after the clock edge that accepts valid beat k+2. outChan and outSos are the inChan and inSos of beat k.
- R7: A cycle with inValid low neither advances the pipeline nor produces an output. outValid is low after that edge, and no sample is lost or repeated.
- R8: Each full-precision term is shifted right arithmetically by truncShift (0 to 63) before it is clamped.
- R9: Signed lanes clamp to the range −32768 to 32767. The unsigned lanes clamp to 65535.
- R10: While outValid is low, corrOut and outChan keep their last values.
- R11: outSos is high only together with outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat is valid |
| inChan | input | 10 | Channel number of the beat |
| inSos | input | 1 | Beat is the first channel of a spectrum |
| xRe | input | 16 | X polarisation, real part, signed |
| xIm | input | 16 | X polarisation, imaginary part, signed |
| yRe | input | 16 | Y polarisation, real part, signed |
| yIm | input | 16 | Y polarisation, imaginary part, signed |
| truncShift | input | 6 | Static right-shift applied to the full-precision terms |
| outValid | output | 1 | Output beat is valid |
| outChan | output | 10 | Channel number of the output beat |
| outSos | output | 1 | Output beat starts a spectrum |
| corrOut | output | 64 | Four 16-bit lanes: X power, Y power, cross real, cross imaginary |

## Verification
The bench sweeps every combination of eight extreme and ordinary component values, including −32768, −1 and 32767, at several shift settings. This exercises the cases where (−32768)² pushes the power term into bit 31, where the cross terms reach +2³¹, and where a result sits exactly at a clamp edge. A design that used a 32-bit sum, or that truncated without saturating, returns wrapped or negative values in those cases. A design with the wrong sign convention in the imaginary lane returns a negated value. Idle cycles are inserted at regular intervals. A pipeline that advanced during an idle cycle, or that flagged a bubble as valid, would return a misaligned sample or channel tag, or would change a held output.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;   // accept a beat into the pipeline
    logic loadOut;   // a finished result reaches the output register
  } dpcStrobe_t;

  typedef enum logic [1:0] {
    LANE_XX = 2'd0,
    LANE_YY = 2'd1,
    LANE_RE = 2'd2,
    LANE_IM = 2'd3
  } dpcLane_e;

  localparam int NUM_LANES = 4;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int CHAN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CHAN_W-1:0] inChan,
  input  logic              inSos,
  output dpcStrobe_t        strobe,
  output logic              outValid,
  output logic [CHAN_W-1:0] outChan,
  output logic              outSos
);
  logic              fill1, fill2;
  logic [CHAN_W-1:0] chan1, chan2;
  logic              sos1, sos2;

  assign strobe.advance = inValid;
  assign strobe.loadOut = inValid & fill2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill1    <= 1'b0;
      fill2    <= 1'b0;
      chan1    <= '0;
      chan2    <= '0;
      sos1     <= 1'b0;
      sos2     <= 1'b0;
      outValid <= 1'b0;
      outChan  <= '0;
      outSos   <= 1'b0;
    end else begin
      if (strobe.advance) begin
        fill1 <= 1'b1;
        fill2 <= fill1;
        chan1 <= inChan;
        chan2 <= chan1;
        sos1  <= inSos;
        sos2  <= sos1;
      end
      outValid <= strobe.loadOut;
      outSos   <= strobe.loadOut & sos2;
      if (strobe.loadOut) outChan <= chan2;
    end
  end
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter  int SAMPLE_W = 16,
  parameter  int OUT_W    = 16,
  localparam int FULL_W   = 2 * SAMPLE_W + 1,
  localparam int SHIFT_W  = $clog2(FULL_W)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpcStrobe_t                 strobe,
  input  logic [SAMPLE_W-1:0]        xRe,
  input  logic [SAMPLE_W-1:0]        xIm,
  input  logic [SAMPLE_W-1:0]        yRe,
  input  logic [SAMPLE_W-1:0]        yIm,
  input  logic [SHIFT_W-1:0]         truncShift,
  output logic [NUM_LANES*OUT_W-1:0] corrOut
);
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam logic signed [FULL_W-1:0] UMAX = FULL_W'((64'd1 << OUT_W) - 64'd1);
  localparam logic signed [FULL_W-1:0] SMAX = FULL_W'((64'd1 << (OUT_W - 1)) - 64'd1);
  localparam logic signed [FULL_W-1:0] SMIN = ~SMAX;

  // stage 1: registered samples
  logic signed [SAMPLE_W-1:0] sxr, sxi, syr, syi;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sxr <= '0; sxi <= '0; syr <= '0; syi <= '0;
    end else if (strobe.advance) begin
      sxr <= xRe; sxi <= xIm; syr <= yRe; syi <= yIm;
    end
  end

  // stage 2: full-precision terms
  logic signed [PROD_W-1:0] pXrXr, pXiXi, pYrYr, pYiYi, pXrYr, pXiYi, pXiYr, pXrYi;
  assign pXrXr = sxr * sxr;
  assign pXiXi = sxi * sxi;
  assign pYrYr = syr * syr;
  assign pYiYi = syi * syi;
  assign pXrYr = sxr * syr;
  assign pXiYi = sxi * syi;
  assign pXiYr = sxi * syr;
  assign pXrYi = sxr * syi;

  logic signed [NUM_LANES-1:0][FULL_W-1:0] fullLane;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullLane <= '0;
    end else if (strobe.advance) begin
      fullLane[LANE_XX] <= FULL_W'(pXrXr) + FULL_W'(pXiXi);
      fullLane[LANE_YY] <= FULL_W'(pYrYr) + FULL_W'(pYiYi);
      fullLane[LANE_RE] <= FULL_W'(pXrYr) + FULL_W'(pXiYi);
      fullLane[LANE_IM] <= FULL_W'(pXiYr) - FULL_W'(pXrYi);
    end
  end

  // stage 3: shift window and clamp, one lane per generate pass
  logic [NUM_LANES-1:0][OUT_W-1:0] clippedBus;
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic signed [FULL_W-1:0] laneFull, shifted;
    logic [OUT_W-1:0] clipped;
    assign laneFull = fullLane[g];
    assign shifted  = laneFull >>> truncShift;
    if (g == int'(LANE_XX) || g == int'(LANE_YY)) begin : gUns
      always_comb begin
        if (shifted > UMAX) clipped = '1;
        else                clipped = shifted[OUT_W-1:0];
      end
    end else begin : gSgn
      always_comb begin
        if (shifted > SMAX)      clipped = SMAX[OUT_W-1:0];
        else if (shifted < SMIN) clipped = SMIN[OUT_W-1:0];
        else                     clipped = shifted[OUT_W-1:0];
      end
    end
    assign clippedBus[g] = clipped;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               corrOut <= '0;
    else if (strobe.loadOut) corrOut <= clippedBus;
  end
endmodule

// File: rtl/dual_pol_correlator.sv
module dual_pol_correlator
  import dpc_pkg::*;
#(
  parameter  int SAMPLE_W = 16,
  parameter  int CHAN_W   = 10,
  parameter  int OUT_W    = 16,
  localparam int SHIFT_W  = $clog2(2 * SAMPLE_W + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [CHAN_W-1:0]          inChan,
  input  logic                       inSos,
  input  logic [SAMPLE_W-1:0]        xRe,
  input  logic [SAMPLE_W-1:0]        xIm,
  input  logic [SAMPLE_W-1:0]        yRe,
  input  logic [SAMPLE_W-1:0]        yIm,
  input  logic [SHIFT_W-1:0]         truncShift,
  output logic                       outValid,
  output logic [CHAN_W-1:0]          outChan,
  output logic                       outSos,
  output logic [NUM_LANES*OUT_W-1:0] corrOut
);
  dpcStrobe_t strobe;

  dpc_ctrl #(.CHAN_W(CHAN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan), .inSos(inSos),
    .strobe(strobe), .outValid(outValid), .outChan(outChan), .outSos(outSos)
  );

  dpc_datapath #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm),
    .truncShift(truncShift), .corrOut(corrOut)
  );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int CHAN_W = 10,
  parameter int OUT_W  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                outValid,
  input logic                outSos,
  input logic [CHAN_W-1:0]   outChan,
  input logic [4*OUT_W-1:0]  corrOut
);
  logic [1:0] beats;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         beats <= 2'd0;
    else if (inValid && beats != 2'd3) beats <= beats + 2'd1;
  end

  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> beats == 2'd3); // R6
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(corrOut)); // R10
  AST_HOLD_CHAN: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outChan)); // R10
  AST_SOS_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    outSos |-> outValid); // R11
endmodule

bind dual_pol_correlator dpc_checker #(.CHAN_W(CHAN_W), .OUT_W(OUT_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outSos(outSos), .outChan(outChan), .corrOut(corrOut)
);

// File: tb/dual_pol_correlator_test.sv
module dual_pol_correlator_test;
  localparam int CHAN_W = 10;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inSos = 1'b0;
  logic [CHAN_W-1:0] inChan = '0;
  logic [15:0] xRe = '0, xIm = '0, yRe = '0, yIm = '0;
  logic [5:0] truncShift = '0;
  logic outValid, outSos;
  logic [CHAN_W-1:0] outChan;
  logic [63:0] corrOut;

  dual_pol_correlator uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan), .inSos(inSos),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm), .truncShift(truncShift),
    .outValid(outValid), .outChan(outChan), .outSos(outSos), .corrOut(corrOut)
  );

  always #5 clk = ~clk;

  typedef struct {
    int xr, xi, yr, yi;
    logic [CHAN_W-1:0] chan;
    logic sos;
  } pend_t;
  pend_t pending[$];

  int checks = 0, errors = 0, fill = 0, beat = 0;
  logic expValid = 1'b0;
  logic [63:0] lastOut = '0;
  logic [CHAN_W-1:0] lastChan = '0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] model(int xr, int xi, int yr, int yi, int sh);
    longint f[4];
    longint s;
    logic [63:0] r;
    f[0] = longint'(xr) * xr + longint'(xi) * xi;
    f[1] = longint'(yr) * yr + longint'(yi) * yi;
    f[2] = longint'(xr) * yr + longint'(xi) * yi;
    f[3] = longint'(xi) * yr - longint'(xr) * yi;
    for (int k = 0; k < 4; k++) begin
      s = f[k] >>> sh;
      if (k < 2) begin
        if (s > 65535) s = 65535;
      end else begin
        if (s > 32767) s = 32767;
        else if (s < -32768) s = -32768;
      end
      r[k*16 +: 16] = 16'(s);
    end
    return r;
  endfunction

  task automatic step(bit v, int xr, int xi, int yr, int yi);
    pend_t e;
    logic [63:0] m;
    @(negedge clk);
    check(outValid == expValid, "R6 R7", "outValid", 64'(outValid), 64'(expValid));
    if (expValid) begin
      e = pending.pop_front();
      m = model(e.xr, e.xi, e.yr, e.yi, int'(truncShift));
      check(corrOut[15:0]  == m[15:0],  "R2 R8 R9", "x power lane",  64'(corrOut[15:0]),  64'(m[15:0]));
      check(corrOut[31:16] == m[31:16], "R3 R8 R9", "y power lane",  64'(corrOut[31:16]), 64'(m[31:16]));
      check(corrOut[47:32] == m[47:32], "R4 R8 R9", "cross real",    64'(corrOut[47:32]), 64'(m[47:32]));
      check(corrOut[63:48] == m[63:48], "R5 R8 R9", "cross imag",    64'(corrOut[63:48]), 64'(m[63:48]));
      check(outChan == e.chan, "R6", "outChan", 64'(outChan), 64'(e.chan));
      check(outSos == e.sos, "R6", "outSos", 64'(outSos), 64'(e.sos));
      lastOut  = corrOut;
      lastChan = outChan;
    end else begin
      check(corrOut == lastOut, "R10", "held corrOut", corrOut, lastOut);
      check(outChan == lastChan, "R10", "held outChan", 64'(outChan), 64'(lastChan));
      check(outSos == 1'b0, "R11", "outSos in bubble", 64'(outSos), 64'd0);
    end
    inValid = v;
    xRe = 16'(xr); xIm = 16'(xi); yRe = 16'(yr); yIm = 16'(yi);
    expValid = v && (fill >= 2);
    if (v) begin
      inChan = CHAN_W'(beat % 1024);
      inSos  = (beat % 1024) == 0;
      e.xr = xr; e.xi = xi; e.yr = yr; e.yi = yi;
      e.chan = inChan; e.sos = inSos;
      pending.push_back(e);
      fill++;
      beat++;
    end
  endtask

  int vals[8] = '{0, 1, -1, 32767, -32768, 12345, -20000, 255};
  int shifts[4] = '{0, 15, 17, 32};

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0 && outSos == 1'b0, "R1", "flags in reset", {62'd0, outValid, outSos}, 64'd0);
    check(corrOut == '0, "R1", "corrOut in reset", corrOut, 64'd0);
    check(outChan == '0, "R1", "outChan in reset", 64'(outChan), 64'd0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0);
    check(corrOut == '0 && outValid == 1'b0, "R1", "after reset", corrOut, 64'd0);
    for (int s = 0; s < 4; s++) begin
      // change the static shift during a bubble (R8)
      step(0, 0, 0, 0, 0);
      truncShift = 6'(shifts[s]);
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int c = 0; c < 8; c++)
            for (int d = 0; d < 8; d++) begin
              if ((beat % 7) == 5) step(0, 7, 7, 7, 7); // R7 bubble with junk data
              step(1, vals[a], vals[b], vals[c], vals[d]);
            end
    end
    for (int t = 0; t < 4; t++) step(0, 0, 0, 0, 0);
    check(pending.size() == 2, "R7", "samples left in pipeline", 64'(pending.size()), 64'd2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule